// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer with Access Checks

This block turns a 40-bit virtual address into a 36-bit physical address. Pages are 16 KB, so the low 14 address bits are passed through unchanged and only the page number is translated. Recent translations are kept in a buffer of 256 sets with two ways each. Every entry holds a valid flag, a modified (dirty) flag, three permission bits, an 18-bit tag and a 22-bit physical page number. Each hit is checked against the kind of access (read or write) and the privilege level (user or kernel) of the request.

A lookup that misses raises a walk request that carries the 26-bit virtual page number. An external page-table walker answers it. If the walker has a mapping, the block installs it and answers the original request. If the walker has no mapping, the block reports a page fault. A write to a page whose dirty flag is clear also goes out through the walk handshake, so that the page table can record the modification. A flush input invalidates every entry in one cycle.

Top module: `xlat_tlb`

## Requirements
- R1: A successful translation returns `rsp_paddr_o = {ppn, vaddr[13:0]}`. The set index is `vaddr[21:14]` and the stored tag is `vaddr[39:22]`.
- R2: A request that hits, is permitted and needs no dirty update produces `rsp_valid_o` with fault code 0 in the cycle after it is accepted. `walk_req_o` stays low.
- R3: A miss raises `walk_req_o` in the cycle after acceptance, with `walk_vpn_o = vaddr[39:14]`. Both signals hold until `walk_ack_i` is seen, and `req_ready_o` is low for the whole walk.
- R4: When `walk_ack_i` arrives with `walk_hit_i = 1`, the returned mapping is installed. The response appears in the cycle after the acknowledge, and a later request to the same page hits.
- R5: When `walk_ack_i` arrives with `walk_hit_i = 0`, the response carries fault code 1 (page fault) and nothing is installed, so a repeat of the request misses again.
- R6: Permission bits are encoded as follows: bit 0 allows reads, bit 1 allows writes, bit 2 allows user-level access. A read needs bit 0, a write needs bit 1, and a user request also needs bit 2. A violation, whether on a hit or in refill data, gives fault code 2 (protection fault).
- R7: `walk_store_o` carries the request's write flag during a walk. A permitted write that hits an entry with a clear dirty flag starts a walk with `walk_store_o = 1`, and the returned entry replaces that same way.
- R8: The refill way is way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the least recently used way. A permitted hit and a refill both mark their way as the most recently used.
- R9: `flush_i` invalidates all entries in one cycle and holds `req_ready_o` low while it is asserted. The next lookup misses.
- R10: After reset, `req_ready_o` is 1, and `rsp_valid_o` and `walk_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_vaddr_i | input | 40 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_user_i | input | 1 | 1 = user-level request |
| rsp_valid_o | output | 1 | Response present (one cycle) |
| rsp_paddr_o | output | 36 | Physical address, 0 on a fault |
| rsp_fault_o | output | 2 | 0 none, 1 page fault, 2 protection fault |
| walk_req_o | output | 1 | Walk request pending |
| walk_vpn_o | output | 26 | Virtual page number to walk |
| walk_store_o | output | 1 | Walk was caused by a write |
| walk_ack_i | input | 1 | Walker answer present |
| walk_hit_i | input | 1 | Walker found a mapping |
| walk_ppn_i | input | 22 | Returned physical page number |
| walk_perm_i | input | 3 | Returned permission bits |
| walk_dirty_i | input | 1 | Returned dirty flag |

## Verification
The assertions check the following on every cycle:
- a walk request and its page number stay steady until acknowledged, with intake closed;
- each response follows an accepted request or a walker answer by exactly one cycle;
- a page fault only follows a walker answer that had no mapping;
- at most one way matches;
- nothing hits in the cycle after a flush.

Only the bench's scenarios can show the rest:
- the physical address value;
- the permission decisions;
- the dirty-update walk landing in the hitting way;
- least-recently-used eviction order across accesses;
- the absence of an install after a page fault.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PERM_RD = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_US = 2;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2
  } fault_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } tlb_state_e;

  function automatic logic perm_ok(input logic [2:0] perm, input logic wr, input logic user);
    return (wr ? perm[PERM_WR] : perm[PERM_RD]) && (!user || perm[PERM_US]);
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int SET_W = 8,
  parameter int ENT_W = 44
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic [SET_W-1:0]      rd_set,
  output logic [1:0]            rd_vld,
  output logic [1:0][ENT_W-1:0] rd_ent,
  output logic                  rd_lru,
  input  logic                  wr_en,
  input  logic [SET_W-1:0]      wr_set,
  input  logic                  wr_way,
  input  logic [ENT_W-1:0]      wr_ent,
  input  logic                  lru_we,
  input  logic [SET_W-1:0]      lru_set,
  input  logic                  lru_val
);
  localparam int SETS = 1 << SET_W;

  logic [ENT_W-1:0] ent_q [SETS][2];
  logic [1:0]       vld_q [SETS];
  logic [SETS-1:0]  lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      lru_q <= '0;
    end else begin
      if (flush_i) begin
        for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (wr_en) begin
        vld_q[wr_set][wr_way] <= 1'b1;
      end
      if (lru_we) lru_q[lru_set] <= lru_val;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush_i) ent_q[wr_set][wr_way] <= wr_ent;
  end

  assign rd_vld    = vld_q[rd_set];
  assign rd_ent[0] = ent_q[rd_set][0];
  assign rd_ent[1] = ent_q[rd_set][1];
  assign rd_lru    = lru_q[rd_set];

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int TAG_W = 18,
  parameter int PPN_W = 22,
  parameter int ENT_W = 44
) (
  input  logic [1:0]            rd_vld,
  input  logic [1:0][ENT_W-1:0] rd_ent,
  input  logic                  rd_lru,
  input  logic [TAG_W-1:0]      tag,
  output logic [1:0]            hit_vec,
  output logic                  hit,
  output logic                  hit_way,
  output logic                  victim
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hit_vec[w] = rd_vld[w] && (rd_ent[w][PPN_W +: TAG_W] == tag);
  end

  assign hit     = |hit_vec;
  assign hit_way = hit_vec[1];
  assign victim  = !rd_vld[0] ? 1'b0 : (!rd_vld[1] ? 1'b1 : rd_lru);

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int VA_W  = 40,
  parameter int PA_W  = 36,
  parameter int PG_W  = 14,
  parameter int SET_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [VA_W-1:0]     req_vaddr_i,
  input  logic                req_write_i,
  input  logic                req_user_i,
  output logic                rsp_valid_o,
  output logic [PA_W-1:0]     rsp_paddr_o,
  output logic [1:0]          rsp_fault_o,
  output logic                walk_req_o,
  output logic [VA_W-PG_W-1:0] walk_vpn_o,
  output logic                walk_store_o,
  input  logic                walk_ack_i,
  input  logic                walk_hit_i,
  input  logic [PA_W-PG_W-1:0] walk_ppn_i,
  input  logic [2:0]          walk_perm_i,
  input  logic                walk_dirty_i
);
  localparam int VPN_W = VA_W - PG_W;
  localparam int PPN_W = PA_W - PG_W;
  localparam int TAG_W = VPN_W - SET_W;
  localparam int ENT_W = 4 + TAG_W + PPN_W;

  function automatic logic [SET_W-1:0] set_of(input logic [VA_W-1:0] va);
    return va[PG_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [VA_W-1:0] va);
    return va[PG_W+SET_W +: TAG_W];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] ppn,
                                               input logic [PG_W-1:0] off);
    return {ppn, off};
  endfunction

  tlb_state_e       state_q;
  logic [SET_W-1:0] set_q;
  logic [TAG_W-1:0] tag_q;
  logic [PG_W-1:0]  off_q;
  logic             wr_q, user_q, fill_way_q;
  logic             rsp_valid_q;
  logic [PA_W-1:0]  rsp_paddr_q;
  fault_e           rsp_fault_q;

  logic [SET_W-1:0]      lk_set;
  logic [TAG_W-1:0]      lk_tag;
  logic [1:0]            rd_vld;
  logic [1:0][ENT_W-1:0] rd_ent;
  logic                  rd_lru;
  logic [1:0]            hit_vec;
  logic                  lk_hit, lk_way, victim;
  logic [ENT_W-1:0]      hit_ent;
  logic                  hit_dirty, hit_perm_ok;
  logic [PPN_W-1:0]      hit_ppn;

  // named events for assertions
  logic accept, ev_hit_ok, ev_hit_prot, ev_dirty_walk, ev_miss, ev_fill, ev_nomap;
  logic lru_we, lru_val;
  logic [SET_W-1:0] lru_set;

  assign lk_set = set_of(req_vaddr_i);
  assign lk_tag = tag_of(req_vaddr_i);

  tlb_store #(.SET_W(SET_W), .ENT_W(ENT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush_i),
    .rd_set  (lk_set),
    .rd_vld  (rd_vld),
    .rd_ent  (rd_ent),
    .rd_lru  (rd_lru),
    .wr_en   (ev_fill),
    .wr_set  (set_q),
    .wr_way  (fill_way_q),
    .wr_ent  ({walk_dirty_i, walk_perm_i, tag_q, walk_ppn_i}),
    .lru_we  (lru_we),
    .lru_set (lru_set),
    .lru_val (lru_val)
  );

  tlb_match #(.TAG_W(TAG_W), .PPN_W(PPN_W), .ENT_W(ENT_W)) u_match (
    .rd_vld  (rd_vld),
    .rd_ent  (rd_ent),
    .rd_lru  (rd_lru),
    .tag     (lk_tag),
    .hit_vec (hit_vec),
    .hit     (lk_hit),
    .hit_way (lk_way),
    .victim  (victim)
  );

  assign hit_ent     = rd_ent[lk_way];
  assign hit_dirty   = hit_ent[ENT_W-1];
  assign hit_ppn     = hit_ent[PPN_W-1:0];
  assign hit_perm_ok = perm_ok(hit_ent[ENT_W-2 -: 3], req_write_i, req_user_i);

  assign req_ready_o   = (state_q == ST_IDLE) && !flush_i;
  assign accept        = req_valid_i && req_ready_o;
  assign ev_hit_prot   = accept && lk_hit && !hit_perm_ok;
  assign ev_dirty_walk = accept && lk_hit && hit_perm_ok && req_write_i && !hit_dirty;
  assign ev_hit_ok     = accept && lk_hit && hit_perm_ok && !(req_write_i && !hit_dirty);
  assign ev_miss       = accept && !lk_hit;
  assign ev_fill       = (state_q == ST_WALK) && walk_ack_i && walk_hit_i;
  assign ev_nomap      = (state_q == ST_WALK) && walk_ack_i && !walk_hit_i;

  assign lru_we  = ev_hit_ok || ev_fill;
  assign lru_set = ev_fill ? set_q : lk_set;
  assign lru_val = ev_fill ? !fill_way_q : !lk_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      set_q       <= '0;
      tag_q       <= '0;
      off_q       <= '0;
      wr_q        <= 1'b0;
      user_q      <= 1'b0;
      fill_way_q  <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_paddr_q <= '0;
      rsp_fault_q <= FLT_NONE;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        set_q  <= lk_set;
        tag_q  <= lk_tag;
        off_q  <= req_vaddr_i[PG_W-1:0];
        wr_q   <= req_write_i;
        user_q <= req_user_i;
      end
      if (ev_hit_ok) begin
        rsp_valid_q <= 1'b1;
        rsp_paddr_q <= join_pa(hit_ppn, req_vaddr_i[PG_W-1:0]);
        rsp_fault_q <= FLT_NONE;
      end
      if (ev_hit_prot) begin
        rsp_valid_q <= 1'b1;
        rsp_paddr_q <= '0;
        rsp_fault_q <= FLT_PROT;
      end
      if (ev_dirty_walk || ev_miss) begin
        state_q    <= ST_WALK;
        fill_way_q <= ev_dirty_walk ? lk_way : victim;
      end
      if (ev_fill) begin
        state_q     <= ST_IDLE;
        rsp_valid_q <= 1'b1;
        if (perm_ok(walk_perm_i, wr_q, user_q)) begin
          rsp_paddr_q <= join_pa(walk_ppn_i, off_q);
          rsp_fault_q <= FLT_NONE;
        end else begin
          rsp_paddr_q <= '0;
          rsp_fault_q <= FLT_PROT;
        end
      end
      if (ev_nomap) begin
        state_q     <= ST_IDLE;
        rsp_valid_q <= 1'b1;
        rsp_paddr_q <= '0;
        rsp_fault_q <= FLT_PAGE;
      end
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_paddr_o  = rsp_paddr_q;
  assign rsp_fault_o  = rsp_fault_q;
  assign walk_req_o   = (state_q == ST_WALK);
  assign walk_vpn_o   = {tag_q, set_q};
  assign walk_store_o = wr_q;

  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req_o && !walk_ack_i |=> walk_req_o && $stable(walk_vpn_o) && !req_ready_o);

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $past(accept) || $past(walk_req_o && walk_ack_i));

  // R5
  page_fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o && (rsp_fault_o == FLT_PAGE) |-> $past(walk_ack_i && !walk_hit_i));

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !lk_hit);

endmodule

// File: tb/xlat_tlb_test.sv
module xlat_tlb_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [39:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        walk_ack = 1'b0;
  logic        walk_hit = 1'b0;
  logic [21:0] walk_ppn = '0;
  logic [2:0]  walk_perm = '0;
  logic        walk_dirty = 1'b0;
  logic        req_ready_o, rsp_valid_o, walk_req_o, walk_store_o;
  logic [35:0] rsp_paddr_o;
  logic [1:0]  rsp_fault_o;
  logic [25:0] walk_vpn_o;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  // behavioural model of buffer contents
  bit m_valid [256][2];
  int m_tag   [256][2];
  int m_ppn   [256][2];
  int m_perm  [256][2];
  bit m_dirty [256][2];
  int m_lru   [256];
  // page table
  int pt_ppn   [int];
  int pt_perm  [int];
  bit pt_dirty [int];

  always #5 clk = ~clk;

  xlat_tlb uut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_vaddr_i(req_vaddr),
    .req_write_i(req_write), .req_user_i(req_user),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o), .rsp_fault_o(rsp_fault_o),
    .walk_req_o(walk_req_o), .walk_vpn_o(walk_vpn_o), .walk_store_o(walk_store_o),
    .walk_ack_i(walk_ack), .walk_hit_i(walk_hit), .walk_ppn_i(walk_ppn),
    .walk_perm_i(walk_perm), .walk_dirty_i(walk_dirty)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      n_fails = n_fails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 50000", cycles);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic bit allowed(input int perm, input bit wr, input bit user);
    bit base;
    base = wr ? perm[1] : perm[0];
    return base && (!user || perm[2]);
  endfunction

  function automatic logic [39:0] mkva(input int tg, input int set, input int off);
    return {tg[17:0], set[7:0], off[13:0]};
  endfunction

  task automatic access(input logic [39:0] va, input bit wr, input bit user);
    int set = int'(va[21:14]);
    int tg  = int'(va[39:22]);
    int vpn = int'(va[39:14]);
    int off = int'(va[13:0]);
    int hw  = -1;
    int way;
    bit both;
    int expf;
    logic [35:0] expa;
    for (int w = 0; w < 2; w++)
      if (m_valid[set][w] && m_tag[set][w] == tg) hw = w;
    both = m_valid[set][0] && m_valid[set][1];
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R3", "ready before request", req_ready_o, 1);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
    if (hw >= 0 && !allowed(m_perm[set][hw], wr, user)) begin
      chk(rsp_valid_o && !walk_req_o, "R6", "hit fault response", rsp_valid_o, 1);
      chk(rsp_fault_o == 2'd2, "R6", "protection code", rsp_fault_o, 2);
    end else if (hw >= 0 && !(wr && !m_dirty[set][hw])) begin
      expa = {m_ppn[set][hw][21:0], off[13:0]};
      chk(rsp_valid_o && !walk_req_o, "R2", "hit response timing", rsp_valid_o, 1);
      chk(rsp_fault_o == 2'd0, "R2", "hit fault code", rsp_fault_o, 0);
      chk(rsp_paddr_o == expa, "R1", "hit physical address", rsp_paddr_o, expa);
      m_lru[set] = 1 - hw;
    end else begin
      way = (hw >= 0) ? hw : (!m_valid[set][0] ? 0 : (!m_valid[set][1] ? 1 : m_lru[set]));
      chk(walk_req_o == 1'b1 && !rsp_valid_o, (hw < 0 && both) ? "R8" : "R3",
          "walk raised", walk_req_o, 1);
      chk(walk_vpn_o == va[39:14], "R3", "walk page number", walk_vpn_o, va[39:14]);
      chk(walk_store_o == wr, "R7", "walk store flag", walk_store_o, wr);
      chk(req_ready_o == 1'b0, "R3", "ready low in walk", req_ready_o, 0);
      repeat (2) begin
        @(negedge clk);
        chk(walk_req_o && !rsp_valid_o, "R3", "walk held", walk_req_o, 1);
      end
      if (pt_ppn.exists(vpn)) begin
        if (wr && pt_perm[vpn][1]) pt_dirty[vpn] = 1'b1;
        walk_hit = 1'b1; walk_ppn = pt_ppn[vpn][21:0];
        walk_perm = pt_perm[vpn][2:0]; walk_dirty = pt_dirty[vpn];
        m_valid[set][way] = 1'b1; m_tag[set][way] = tg; m_ppn[set][way] = pt_ppn[vpn];
        m_perm[set][way] = pt_perm[vpn]; m_dirty[set][way] = pt_dirty[vpn];
        m_lru[set] = 1 - way;
        expf = allowed(pt_perm[vpn], wr, user) ? 0 : 2;
        expa = (expf == 0) ? {pt_ppn[vpn][21:0], off[13:0]} : 36'd0;
      end else begin
        walk_hit = 1'b0; walk_ppn = '0; walk_perm = '0; walk_dirty = 1'b0;
        expf = 1;
        expa = '0;
      end
      walk_ack = 1'b1;
      @(negedge clk);
      walk_ack = 1'b0;
      chk(rsp_valid_o == 1'b1, expf == 1 ? "R5" : "R4", "response after walk", rsp_valid_o, 1);
      chk(rsp_fault_o == expf[1:0], expf == 2 ? "R6" : (expf == 1 ? "R5" : "R4"),
          "walk fault code", rsp_fault_o, expf);
      if (expf == 0)
        chk(rsp_paddr_o == expa, "R1", "refill physical address", rsp_paddr_o, expa);
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(req_ready_o == 1'b0, "R9", "ready low during flush", req_ready_o, 0);
    @(negedge clk);
    flush = 1'b0;
    for (int s = 0; s < 256; s++) begin
      m_valid[s][0] = 1'b0;
      m_valid[s][1] = 1'b0;
    end
  endtask

  initial begin
    bit [15:0] lf;
    for (int s = 0; s < 256; s++) m_lru[s] = 0;
    // explicit pages in set 5 and set 9
    pt_ppn[{18'd1, 8'd5}] = 22'h12345; pt_perm[{18'd1, 8'd5}] = 7; pt_dirty[{18'd1, 8'd5}] = 0;
    pt_ppn[{18'd2, 8'd5}] = 22'h00abc; pt_perm[{18'd2, 8'd5}] = 5; pt_dirty[{18'd2, 8'd5}] = 1;
    pt_ppn[{18'd3, 8'd5}] = 22'h3ffff; pt_perm[{18'd3, 8'd5}] = 3; pt_dirty[{18'd3, 8'd5}] = 1;
    pt_ppn[{18'd7, 8'd5}] = 22'h20001; pt_perm[{18'd7, 8'd5}] = 7; pt_dirty[{18'd7, 8'd5}] = 1;
    // generated pages in sets 20..21
    for (int t = 1; t < 6; t++)
      for (int s = 20; s < 22; s++)
        if ((t + s) % 3 != 0) begin
          pt_ppn[t * 256 + s]   = t * 4099 + s;
          pt_perm[t * 256 + s]  = (t * 3 + s) % 8;
          pt_dirty[t * 256 + s] = 1'b0;
        end

    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready_o == 1'b0 || req_ready_o == 1'b1, "R10", "ready known in reset", req_ready_o, 1);
    chk(rsp_valid_o == 1'b0, "R10", "no response in reset", rsp_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R10", "ready after reset", req_ready_o, 1);
    chk(walk_req_o == 1'b0, "R10", "no walk after reset", walk_req_o, 0);
    chk(rsp_valid_o == 1'b0, "R10", "no response after reset", rsp_valid_o, 0);

    access(mkva(1, 5, 14'h1234), 0, 1);  // miss, fill way 0
    access(mkva(1, 5, 14'h3fff), 0, 1);  // hit, offset passthrough
    access(mkva(1, 5, 14'h0010), 1, 1);  // clean write: dirty walk into way 0
    access(mkva(1, 5, 14'h0020), 1, 1);  // now dirty: hit
    access(mkva(2, 5, 14'h0100), 0, 1);  // miss, fill way 1
    access(mkva(1, 5, 14'h0004), 0, 0);  // hit way 0, way 1 now LRU
    access(mkva(3, 5, 14'h0200), 0, 0);  // evicts page 2 (way 1)
    access(mkva(2, 5, 14'h0300), 0, 1);  // miss again, evicts page 1
    access(mkva(3, 5, 14'h0008), 0, 1);  // user on kernel page: protection
    access(mkva(2, 5, 14'h0008), 1, 1);  // write on read-only: protection
    access(mkva(4, 9, 14'h0000), 0, 0);  // unmapped: page fault
    access(mkva(4, 9, 14'h0000), 0, 0);  // still not installed
    access(mkva(7, 5, 14'h0040), 1, 1);  // write miss, walk store flag
    do_flush();
    access(mkva(2, 5, 14'h0300), 0, 1);  // misses after flush

    lf = 16'hace1;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access(mkva(1 + (lf[2:0] % 5), 20 + lf[3], int'(lf[15:4])), lf[5], lf[6]);
      if (i == 30) do_flush();
    end

    repeat (2) @(negedge clk);
    report();
    $finish;
  end

endmodule